// File: doc/BRIEF.md
# Three-Channel Compare Interval Timer

This block is a register-mapped up-counter for timekeeping and periodic events. A prescaler divides a single tick-enable input, which stands in for the chosen clock source, and the counter advances once per divided tick. Three compare channels watch the counter. Each one latches its own sticky status flag when the count reaches its value. A fourth flag records the count wrapping from all ones back to zero.

Two counting modes are available. In free-running mode the counter runs through its whole range and wraps. In restart mode the counter returns to zero on the step after it reaches the channel-1 compare value, which gives a period of compare-1 + 1 steps. Software reads and writes the registers over a word-addressed bus with a write strobe and combinational read data. Software clears flags by writing ones to them. The single level interrupt is high while the timer is enabled and any flag is set whose enable bit is also set.

Top module: `cmp3_timer`

## Requirements
- R1: Word offsets are: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare channels 1/2/3, 7/8 capture 1/2, 9 current count. A read at any other offset returns 0.
- R2: The prescaler register keeps only its low 12 bits. While the timer is enabled, the count advances once every (prescale + 1) cycles in which tick is high.
- R3: Status bit 0, bit 1 and bit 2 are the compare 1, 2 and 3 flags, and bit 5 is the rollover flag. A flag stays set until a status write carries a 1 in its position. A status write clears exactly the low-6 bit positions written as 1.
- R4: The interrupt-enable register stores the low 6 bits written, with the same bit positions as the status flags.
- R5: irq is high exactly when control bit 0 (enable) is set and status AND interrupt-enable is nonzero.
- R6: When control bit 9 is 1 (free-running), the count goes from all ones to 0 and sets status bit 5.
- R7: When control bit 9 is 0 (restart), the count returns to 0 on the step after it equals compare 1. Reaching the compare-1 value sets status bit 0.
- R8: A step that brings the count to a value equal to several compare registers sets all of the matching flags in the same cycle.
- R9: A write to compare 1 while in restart mode sets the count to 0. In free-running mode the same write leaves the count unchanged.
- R10: A control write that sets enable while enable was 0 clears the count if control bit 1 (enable-mode) is also written as 1, and keeps the count otherwise. While enable is 0 the count does not change.
- R11: A control write with bit 15 set performs a soft reset: control, status and count become 0 and all three compares become all ones. Bit 15 always reads as 0.
- R12: Capture registers read 0. Writes to the capture and count offsets change nothing.
- R13: After rst_n, control, status and interrupt-enable read 0, the compares read all ones, the count reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Source tick enable feeding the prescaler |
| addr | input | AW (4) | Word offset of the register accessed |
| wr_en | input | 1 | Write strobe for addr/wdata |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is the all-ones-to-zero wrap. It is hard at full width because it needs billions of steps. The bench therefore builds the block with an 8-bit counter and drives whole wrap cycles, sweeping prescale values against tick counts on both sides of 256 steps. Restart mode is swept over several compare-1 values and every tick count up to 20, and the bench predicts the count as a remainder. The equal-compare case is set up by loading all three channels with one value.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // register word offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_PRE  = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_IEN  = 3;
  localparam int OFF_CMP1 = 4;
  localparam int OFF_CAP1 = 7;
  localparam int OFF_CAP2 = 8;
  localparam int OFF_CNT  = 9;
  // control bits
  localparam int CB_EN    = 0;
  localparam int CB_ENMOD = 1;
  localparam int CB_FREE  = 9;
  localparam int CB_SRST  = 15;
  // status / enable flag layout
  localparam int FLG_W    = 6;
  localparam int FLG_ROLL = 5;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             sync_clr,
  input  logic [PRE_W-1:0] pre,
  output logic             step
);
  logic [PRE_W-1:0] phase_q;

  function automatic logic phase_done(input logic [PRE_W-1:0] ph,
                                      input logic [PRE_W-1:0] lim);
    return ph == lim;
  endfunction

  assign step = run && tick && phase_done(phase_q, pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (!run || sync_clr) phase_q <= '0;
    else if (tick)             phase_q <= phase_done(phase_q, pre) ? '0 : phase_q + 1'b1;
  end

  // R2
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pre != '0) |=> (!step || !$stable(pre)));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             clr,
  input  logic             free_run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] cur,
                                                input logic free,
                                                input logic [CNT_W-1:0] lim);
    if (!free && cur == lim) return '0;
    return cur + 1'b1;
  endfunction

  assign cnt_next = advance(cnt_q, free_run, limit);
  assign wrap     = step && (&cnt_q);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (step) cnt_q <= cnt_next;
  end

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  // R10
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_match.sv
`timescale 1ns/1ps
module tmr_match #(
  parameter int CNT_W = 32,
  parameter int NCH   = 3
) (
  input  logic                      step,
  input  logic [CNT_W-1:0]          cnt_next,
  input  logic [NCH-1:0][CNT_W-1:0] cmp,
  output logic [NCH-1:0]            hit
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign hit[g] = step && (cnt_next == cmp[g]);
  end
endmodule

// File: rtl/cmp3_timer.sv
`timescale 1ns/1ps
module cmp3_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12,
  parameter int DW    = 32,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int NCH = 3;

  logic [DW-1:0]             ctrl_q;
  logic [PRE_W-1:0]          pre_q;
  logic [FLG_W-1:0]          stat_q, ien_q;
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]          cnt, cnt_next;
  logic [NCH-1:0]            hit;
  logic                      wrap, step_raw, step, cnt_clr;
  logic                      wr_ctrl, wr_stat, swr, en_rise, cmp1_restart;
  logic [FLG_W-1:0]          flag_set, flag_clr;

  function automatic logic [DW-1:0] widen_cnt(input logic [CNT_W-1:0] v);
    logic [DW-1:0] t;
    t = '0;
    t[CNT_W-1:0] = v;
    return t;
  endfunction

  function automatic logic [DW-1:0] widen_pre(input logic [PRE_W-1:0] v);
    logic [DW-1:0] t;
    t = '0;
    t[PRE_W-1:0] = v;
    return t;
  endfunction

  function automatic logic [FLG_W-1:0] next_flags(input logic [FLG_W-1:0] cur,
                                                   input logic [FLG_W-1:0] setm,
                                                   input logic [FLG_W-1:0] clrm);
    return (cur & ~clrm) | setm;
  endfunction

  // decoded write events
  assign wr_ctrl      = wr_en && addr == AW'(OFF_CTRL);
  assign wr_stat      = wr_en && addr == AW'(OFF_STAT);
  assign swr          = wr_ctrl && wdata[CB_SRST];
  assign en_rise      = wr_ctrl && !swr && wdata[CB_EN] && !ctrl_q[CB_EN] && wdata[CB_ENMOD];
  assign cmp1_restart = wr_en && addr == AW'(OFF_CMP1) && !ctrl_q[CB_FREE];
  assign cnt_clr      = swr || en_rise || cmp1_restart;
  assign step         = step_raw && !cnt_clr;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_EN]), .tick(tick),
    .sync_clr(swr), .pre(pre_q), .step(step_raw));

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CB_EN]), .step(step), .clr(cnt_clr),
    .free_run(ctrl_q[CB_FREE]), .limit(cmp_q[0]), .cnt(cnt),
    .cnt_next(cnt_next), .wrap(wrap));

  tmr_match #(.CNT_W(CNT_W), .NCH(NCH)) u_match (
    .step(step), .cnt_next(cnt_next), .cmp(cmp_q), .hit(hit));

  always_comb begin
    flag_set = '0;
    flag_set[NCH-1:0] = hit;
    flag_set[FLG_ROLL] = wrap;
    flag_clr = wr_stat ? wdata[FLG_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else if (swr) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wdata;
        ctrl_q[CB_SRST] <= 1'b0;
      end
      if (wr_en && addr == AW'(OFF_PRE)) pre_q <= wdata[PRE_W-1:0];
      if (wr_en && addr == AW'(OFF_IEN)) ien_q <= wdata[FLG_W-1:0];
      stat_q <= next_flags(stat_q, flag_set, flag_clr);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_q[g] <= '1;
      else if (swr)   cmp_q[g] <= '1;
      else if (wr_en && addr == AW'(OFF_CMP1 + g)) cmp_q[g] <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      AW'(OFF_CTRL):     rdata = ctrl_q;
      AW'(OFF_PRE):      rdata = widen_pre(pre_q);
      AW'(OFF_STAT):     rdata = DW'(stat_q);
      AW'(OFF_IEN):      rdata = DW'(ien_q);
      AW'(OFF_CMP1):     rdata = widen_cnt(cmp_q[0]);
      AW'(OFF_CMP1 + 1): rdata = widen_cnt(cmp_q[1]);
      AW'(OFF_CMP1 + 2): rdata = widen_cnt(cmp_q[2]);
      AW'(OFF_CNT):      rdata = widen_cnt(cnt);
      default:           rdata = '0;
    endcase
  end

  assign irq = ctrl_q[CB_EN] && ((stat_q & ien_q) != '0);

  // R3
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && !swr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R6
  rollover_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !swr) |=> stat_q[FLG_ROLL]);
  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (cnt == '0 && stat_q == '0 && cmp_q[0] == '1 && !ctrl_q[CB_EN]));
  // R9
  cmp1_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp1_restart |=> (cnt == '0));
endmodule

// File: tb/cmp3_timer_tb.sv
`timescale 1ns/1ps
module cmp3_timer_tb;
  localparam int CW = 8;
  localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, FREE = 32'h200, SRST = 32'h8000;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp3_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic start(input int p, input logic [31:0] c1, input logic [31:0] mode);
    wr(0, 0);
    wr(1, 32'(p));
    wr(4, c1);
    wr(2, 32'h3F);
    wr(0, EN | ENMOD | mode);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13 reset state
    rd(0, v); chk("R13 ctrl", v, 0);
    rd(2, v); chk("R13 status", v, 0);
    rd(3, v); chk("R13 ien", v, 0);
    for (int i = 4; i < 7; i++) begin rd(i, v); chk("R13 compare", v, 32'hFF); end
    rd(9, v); chk("R13 count", v, 0);
    chk("R13 irq", 32'(irq), 0);

    // R1 unmapped offsets
    for (int i = 10; i < 16; i++) begin rd(i, v); chk("R1 unmapped", v, 0); end

    // R2 / R4 field widths
    wr(1, 32'hFFFFF123); rd(1, v); chk("R2 prescale width", v, 32'h123);
    wr(3, 32'hFFFFFFFF); rd(3, v); chk("R4 ien width", v, 32'h3F);
    wr(3, 0);

    // R2 / R6 free-running sweep over prescale and tick counts
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 7; k++) begin
        int n = k * k * 11 + p;
        int s = n / (p + 1);
        start(p, 32'hFF, FREE);
        ticks(n);
        rd(9, v); chk("R2 count vs prescale", v, 32'(s % 256));
        rd(2, v); chk("R6 rollover flag", 32'(v[5]), 32'(s >= 256));
      end
    end
    // R6 exact boundary
    start(0, 32'hFF, FREE); ticks(255);
    rd(9, v); chk("R6 at max", v, 255);
    rd(2, v); chk("R6 no roll yet", 32'(v[5]), 0);
    ticks(1);
    rd(9, v); chk("R6 wrapped", v, 0);
    rd(2, v); chk("R6 roll set", 32'(v[5]), 1);

    // R7 restart sweep
    for (int ci = 0; ci < 5; ci++) begin
      int c = (ci == 4) ? 12 : (1 << ci) - 1;
      for (int n = 0; n <= 20; n++) begin
        start(0, 32'(c), 0);
        ticks(n);
        rd(9, v); chk("R7 restart count", v, 32'(n % (c + 1)));
        rd(2, v); chk("R7 cmp1 flag", 32'(v[0]), 32'(n >= ((c == 0) ? 1 : c)));
      end
    end

    // R8 simultaneous matches, then R3 write-one-to-clear
    wr(0, SRST);
    rd(0, v); chk("R11 srst reads 0", v, 0);
    wr(4, 7); wr(5, 7); wr(6, 7);
    wr(0, EN | ENMOD | FREE);
    ticks(7);
    rd(2, v); chk("R8 all three flags", v, 32'h07);
    wr(2, 32'h02);
    rd(2, v); chk("R3 clear one flag", v, 32'h05);
    ticks(3);
    rd(2, v); chk("R3 flags sticky", v, 32'h05);

    // R5 interrupt gating and R10 enable behaviour
    wr(0, SRST);
    wr(6, 3);
    wr(0, EN | ENMOD | FREE);
    ticks(3);
    chk("R5 no irq without enable mask", 32'(irq), 0);
    wr(3, 32'h04);
    chk("R5 irq raised", 32'(irq), 1);
    wr(0, FREE);
    chk("R5 irq off when disabled", 32'(irq), 0);
    ticks(5);
    rd(9, v); chk("R10 frozen", v, 3);
    wr(0, EN | FREE);
    rd(9, v); chk("R10 enable without enmod keeps count", v, 3);
    chk("R5 irq back", 32'(irq), 1);
    wr(3, 32'h20);
    chk("R5 masked other flag", 32'(irq), 0);
    wr(3, 32'h04); wr(2, 32'h04);
    chk("R5 cleared flag drops irq", 32'(irq), 0);

    // R9 compare-1 write
    ticks(4);
    wr(4, 200);
    rd(9, v); chk("R9 free mode keeps count", v, 7);
    wr(0, 0); wr(0, EN | ENMOD);
    ticks(10);
    rd(9, v); chk("R9 restart count before", v, 10);
    wr(4, 60);
    rd(9, v); chk("R9 restart count cleared", v, 0);

    // R12 ignored writes
    wr(7, 32'h55); wr(8, 32'hAA); wr(9, 32'h77);
    rd(7, v); chk("R12 cap1", v, 0);
    rd(8, v); chk("R12 cap2", v, 0);
    rd(9, v); chk("R12 count write ignored", v, 0);

    // R11 soft reset
    ticks(6);
    wr(0, SRST | EN);
    rd(0, v); chk("R11 ctrl", v, 0);
    rd(9, v); chk("R11 count", v, 0);
    rd(4, v); chk("R11 cmp1", v, 32'hFF);
    rd(2, v); chk("R11 status", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule